// File: doc/BRIEF.md
# Memory Operand Offset Generator

This unit turns the already-decoded addressing fields of an instruction into the offset of its memory operand, plus the segment register that offset belongs to. It accepts the two-bit mode field, the three-bit register/memory field, the scale, index and base fields of the scaled-index byte, a displacement, the current contents of the eight general registers and an optional segment replacement. It handles both the 16-bit register-pair addressing scheme and the 32-bit base plus scaled index scheme.

A single register stage sits between the inputs and the outputs. A request presented with `in_valid` high produces its result one clock later, with `out_valid` high. When the mode field selects a register operand, the unit flags this and passes that register number through. It does not add the segment base, and it does not check limits or paging.

The decoder must supply the displacement already sign-extended to 32 bits. General register index order is 0..7 = EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI, packed with register k in `gpr_flat[32k+31:32k]`. The 16-bit forms use the low halves, named BX, SP, BP, SI, DI after those same registers.

Top module: `ea_gen`

## Requirements
- R1: In 16-bit mode (`addr32`=0), rm selects these offsets: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX. The displacement's low 16 bits are added when mod is 01 or 10, and no displacement is added when mod is 00. The sum wraps modulo 2^16 and is zero-extended to 32 bits.
- R2: In 16-bit mode, mod=00 with rm=110 uses no register, and the offset is the low 16 bits of the displacement.
- R3: In 16-bit mode the default segment is SS (code 2) for rm 010, rm 011, and rm 110 with mod not 00. It is DS (code 3) for every other memory form, including the displacement-only form.
- R4: In 32-bit mode without a scaled index (rm not 100), rm names the base register, and the displacement is added when mod is 01 or 10. mod=00 with rm=101 is a displacement-only form. Sums wrap modulo 2^32.
- R5: In 32-bit mode with rm=100, the offset is base + (index << scale), using scale 0..3 for factors 1, 2, 4 and 8. An index field of 100 contributes zero.
- R6: A scaled-index base field of 101 with mod=00 uses no base register, and adds the 32-bit displacement instead.
- R7: In 32-bit mode the default segment is SS (2) when the base register actually used is ESP or EBP. Otherwise it is DS (3), including both displacement-only forms.
- R8: For a memory form, `seg_ovr_valid`=1 makes the segment output equal `seg_ovr` (ES=0, CS=1, SS=2, DS=3, FS=4, GS=5) in place of the default.
- R9: mod=11 sets `is_reg`=1, `reg_sel`=rm, offset 0 and segment DS (3), whatever the override inputs are.
- R10: Results appear one cycle after `in_valid` with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0 on the next cycle and leaves offset, segment, `is_reg` and `reg_sel` unchanged.
- R11: After synchronous reset, `out_valid`=0, offset=0, segment=DS (3), `is_reg`=0 and `reg_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| mod_f | input | 2 | Mode field |
| rm_f | input | 3 | Register/memory field |
| sib_scale | input | 2 | Scale exponent |
| sib_index | input | 3 | Index register field |
| sib_base | input | 3 | Base register field |
| disp | input | 32 | Sign-extended displacement |
| gpr_flat | input | 256 | Eight general registers, register k at bits 32k+31:32k |
| seg_ovr_valid | input | 1 | Segment replacement present |
| seg_ovr | input | 3 | Replacement segment code |
| out_valid | output | 1 | Result valid |
| offset | output | 32 | Operand offset |
| seg | output | 3 | Segment code |
| is_reg | output | 1 | Operand is a register |
| reg_sel | output | 3 | Register number when `is_reg` |

## Verification
A bad table entry inside either addressing path appears as a wrong offset or a wrong segment code one cycle after the request. Every rm, scale and special form is therefore driven with register values that differ from one another, so a wrong register pick changes the offset. A stuck pipeline register shows up on the next idle cycle, as `out_valid` staying high or the outputs changing without a request. Wrap-around cases push sums past 2^16 and 2^32 so that a missing truncation or a wrong adder width shows up in the top bits immediately.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int unsigned GPR_W  = 32;
  parameter int unsigned GPR_N  = 8;
  parameter int unsigned HALF_W = 16;
  localparam int unsigned RIDX_W = $clog2(GPR_N);

  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_t;

  localparam logic [1:0] MOD_NODISP = 2'b00;
  localparam logic [1:0] MOD_REG    = 2'b11;
endpackage

// File: rtl/ea_path16.sv
module ea_path16
  import ea_pkg::*;
#(
  parameter int unsigned HW = HALF_W
) (
  input  logic [1:0]    mod_f,
  input  logic [2:0]    rm_f,
  input  logic [HW-1:0] disp16,
  input  logic [HW-1:0] r_bx,
  input  logic [HW-1:0] r_bp,
  input  logic [HW-1:0] r_si,
  input  logic [HW-1:0] r_di,
  output logic [HW-1:0] off16,
  output seg_t          seg16
);
  logic [HW-1:0] lhs, rhs;
  logic          disp_only, add_disp;

  assign disp_only = (mod_f == MOD_NODISP) && (rm_f == 3'b110);
  assign add_disp  = (mod_f == 2'b01) || (mod_f == 2'b10) || disp_only;

  always_comb begin
    lhs = '0;
    rhs = '0;
    unique case (rm_f)
      3'b000: begin lhs = r_bx; rhs = r_si; end
      3'b001: begin lhs = r_bx; rhs = r_di; end
      3'b010: begin lhs = r_bp; rhs = r_si; end
      3'b011: begin lhs = r_bp; rhs = r_di; end
      3'b100: lhs = r_si;
      3'b101: lhs = r_di;
      3'b110: lhs = disp_only ? '0 : r_bp;
      default: lhs = r_bx;
    endcase
  end

  assign off16 = lhs + rhs + (add_disp ? disp16 : '0);

  always_comb begin
    if (rm_f == 3'b010 || rm_f == 3'b011 || (rm_f == 3'b110 && !disp_only))
      seg16 = SEG_SS;
    else
      seg16 = SEG_DS;
  end
endmodule

// File: rtl/ea_path32.sv
module ea_path32
  import ea_pkg::*;
#(
  parameter int unsigned W = GPR_W,
  parameter int unsigned N = GPR_N
) (
  input  logic [1:0]          mod_f,
  input  logic [2:0]          rm_f,
  input  logic [1:0]          sib_scale,
  input  logic [2:0]          sib_index,
  input  logic [2:0]          sib_base,
  input  logic [W-1:0]        disp,
  input  logic [N-1:0][W-1:0] gpr,
  output logic [W-1:0]        off32,
  output seg_t                seg32
);
  localparam logic [2:0] CODE_ESC = 3'b100;
  localparam logic [2:0] CODE_BP  = 3'b101;
  localparam logic [2:0] CODE_SP  = 3'b100;

  logic          use_sib, no_base, add_disp;
  logic [2:0]    base_code;
  logic [W-1:0]  base_val, idx_val;

  assign use_sib   = (rm_f == CODE_ESC);
  assign base_code = use_sib ? sib_base : rm_f;
  assign no_base   = (mod_f == MOD_NODISP) && (base_code == CODE_BP);
  assign add_disp  = (mod_f == 2'b01) || (mod_f == 2'b10) || no_base;

  assign base_val = no_base ? '0 : gpr[base_code];
  assign idx_val  = (use_sib && sib_index != CODE_ESC) ? (gpr[sib_index] << sib_scale) : '0;
  assign off32    = base_val + idx_val + (add_disp ? disp : '0);

  always_comb begin
    if (!no_base && (base_code == CODE_SP || base_code == CODE_BP))
      seg32 = SEG_SS;
    else
      seg32 = SEG_DS;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned W  = GPR_W,
  parameter int unsigned N  = GPR_N,
  parameter int unsigned HW = HALF_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           addr32,
  input  logic [1:0]     mod_f,
  input  logic [2:0]     rm_f,
  input  logic [1:0]     sib_scale,
  input  logic [2:0]     sib_index,
  input  logic [2:0]     sib_base,
  input  logic [W-1:0]   disp,
  input  logic [N*W-1:0] gpr_flat,
  input  logic           seg_ovr_valid,
  input  logic [2:0]     seg_ovr,
  output logic           out_valid,
  output logic [W-1:0]   offset,
  output logic [2:0]     seg,
  output logic           is_reg,
  output logic [2:0]     reg_sel
);
  localparam int unsigned I_BX = 3;
  localparam int unsigned I_BP = 5;
  localparam int unsigned I_SI = 6;
  localparam int unsigned I_DI = 7;

  logic [N-1:0][W-1:0] gpr;
  assign gpr = gpr_flat;

  logic [HW-1:0] off16;
  logic [W-1:0]  off32;
  seg_t          seg16, seg32;

  ea_path16 #(.HW(HW)) u_path16 (
    .mod_f (mod_f),
    .rm_f  (rm_f),
    .disp16(disp[HW-1:0]),
    .r_bx  (gpr[I_BX][HW-1:0]),
    .r_bp  (gpr[I_BP][HW-1:0]),
    .r_si  (gpr[I_SI][HW-1:0]),
    .r_di  (gpr[I_DI][HW-1:0]),
    .off16 (off16),
    .seg16 (seg16)
  );

  ea_path32 #(.W(W), .N(N)) u_path32 (
    .mod_f    (mod_f),
    .rm_f     (rm_f),
    .sib_scale(sib_scale),
    .sib_index(sib_index),
    .sib_base (sib_base),
    .disp     (disp),
    .gpr      (gpr),
    .off32    (off32),
    .seg32    (seg32)
  );

  logic          reg_form;
  logic [W-1:0]  off_c;
  logic [2:0]    seg_c;

  assign reg_form = (mod_f == MOD_REG);

  always_comb begin
    if (reg_form) begin
      off_c = '0;
      seg_c = SEG_DS;
    end else begin
      off_c = addr32 ? off32 : {{(W-HW){1'b0}}, off16};
      seg_c = seg_ovr_valid ? seg_ovr : (addr32 ? seg32 : seg16);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      offset    <= '0;
      seg       <= SEG_DS;
      is_reg    <= 1'b0;
      reg_sel   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        offset  <= off_c;
        seg     <= seg_c;
        is_reg  <= reg_form;
        reg_sel <= rm_f;
      end
    end
  end

  p_valid_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(offset) && $stable(seg)));

  p_reg_form_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_reg) |-> (offset == '0 && seg == SEG_DS));

  p_wrap16_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !addr32) |=> (offset[W-1:HW] == '0));

  p_override_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seg_ovr_valid && mod_f != MOD_REG) |=> (seg == $past(seg_ovr)));

  p_default_seg_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !seg_ovr_valid) |=> (seg == SEG_SS || seg == SEG_DS));
endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         addr32;
  logic [1:0]   mod_f;
  logic [2:0]   rm_f;
  logic [1:0]   sib_scale;
  logic [2:0]   sib_index;
  logic [2:0]   sib_base;
  logic [31:0]  disp;
  logic [255:0] gpr_flat;
  logic         seg_ovr_valid;
  logic [2:0]   seg_ovr;
  logic         out_valid;
  logic [31:0]  offset;
  logic [2:0]   seg;
  logic         is_reg;
  logic [2:0]   reg_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ea_gen i_ea_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .addr32(addr32),
    .mod_f(mod_f), .rm_f(rm_f), .sib_scale(sib_scale), .sib_index(sib_index),
    .sib_base(sib_base), .disp(disp), .gpr_flat(gpr_flat),
    .seg_ovr_valid(seg_ovr_valid), .seg_ovr(seg_ovr),
    .out_valid(out_valid), .offset(offset), .seg(seg),
    .is_reg(is_reg), .reg_sel(reg_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input int k, input logic [31:0] v);
    gpr_flat[k*32 +: 32] = v;
  endtask

  // drive one request at a falling edge, sample its result one edge later
  task automatic issue(input logic a32, input logic [1:0] md, input logic [2:0] rm,
                       input logic [1:0] sc, input logic [2:0] ix, input logic [2:0] bs,
                       input logic [31:0] d, input logic ov, input logic [2:0] ovs);
    addr32 = a32; mod_f = md; rm_f = rm; sib_scale = sc; sib_index = ix;
    sib_base = bs; disp = d; seg_ovr_valid = ov; seg_ovr = ovs; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 out_valid", {31'b0, out_valid}, 32'd0);
    check("R11 offset", offset, 32'd0);
    check("R11 seg", {29'b0, seg}, 32'd3);
    check("R11 is_reg", {31'b0, is_reg}, 32'd0);
    check("R11 reg_sel", {29'b0, reg_sel}, 32'd0);
  endtask

  task automatic t_mode16;
    logic [31:0] exp_off [8];
    logic [2:0]  exp_seg [8];
    set_reg(3, 32'hAAAA_0100); set_reg(5, 32'h7777_5000);
    set_reg(6, 32'h9999_0020); set_reg(7, 32'h8888_0003);
    exp_off = '{32'h130, 32'h113, 32'h5030, 32'h5013, 32'h30, 32'h13, 32'h5010, 32'h110};
    exp_seg = '{3'd3, 3'd3, 3'd2, 3'd2, 3'd3, 3'd3, 3'd2, 3'd3};
    for (int r = 0; r < 8; r++) begin
      issue(1'b0, 2'b01, r[2:0], 2'd0, 3'd0, 3'd0, 32'h0000_0010, 1'b0, 3'd0);
      check($sformatf("R1 rm%0d offset", r), offset, exp_off[r]);
      check($sformatf("R3 rm%0d seg", r), {29'b0, seg}, {29'b0, exp_seg[r]});
      check("R10 out_valid", {31'b0, out_valid}, 32'd1);
    end
    issue(1'b0, 2'b00, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_0010, 1'b0, 3'd0);
    check("R1 mod00 no disp", offset, 32'h120);
    set_reg(3, 32'h0000_FFF0);
    issue(1'b0, 2'b10, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_0000, 1'b0, 3'd0);
    check("R1 wrap 2^16", offset, 32'h0000_0010);
    issue(1'b0, 2'b10, 3'd7, 2'd0, 3'd0, 3'd0, 32'hFFFF_FFFF, 1'b0, 3'd0);
    check("R1 negative disp", offset, 32'h0000_FFEF);
    issue(1'b0, 2'b00, 3'd6, 2'd0, 3'd0, 3'd0, 32'h1234_BEEF, 1'b0, 3'd0);
    check("R2 disp-only offset", offset, 32'h0000_BEEF);
    check("R3 disp-only seg DS", {29'b0, seg}, 32'd3);
  endtask

  task automatic t_mode32;
    set_reg(0, 32'h0000_0100); set_reg(1, 32'h0000_0002);
    set_reg(3, 32'h0000_1000); set_reg(4, 32'h0000_7000);
    set_reg(5, 32'h0000_8000); set_reg(6, 32'h0000_0010);
    set_reg(7, 32'hFFFF_FFFF);
    issue(1'b1, 2'b01, 3'd0, 2'd0, 3'd0, 3'd0, 32'hFFFF_FFF0, 1'b0, 3'd0);
    check("R4 EAX+disp8", offset, 32'h0000_00F0);
    check("R7 EAX seg DS", {29'b0, seg}, 32'd3);
    issue(1'b1, 2'b00, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_0044, 1'b0, 3'd0);
    check("R4 mod00 no disp", offset, 32'h0000_0100);
    issue(1'b1, 2'b00, 3'd5, 2'd0, 3'd0, 3'd0, 32'hDEAD_BEEF, 1'b0, 3'd0);
    check("R4 disp32 only", offset, 32'hDEAD_BEEF);
    check("R7 disp32 seg DS", {29'b0, seg}, 32'd3);
    issue(1'b1, 2'b10, 3'd5, 2'd0, 3'd0, 3'd0, 32'h0000_0004, 1'b0, 3'd0);
    check("R4 EBP+disp", offset, 32'h0000_8004);
    check("R7 EBP seg SS", {29'b0, seg}, 32'd2);
    issue(1'b1, 2'b01, 3'd7, 2'd0, 3'd0, 3'd0, 32'h0000_0002, 1'b0, 3'd0);
    check("R4 wrap 2^32", offset, 32'h0000_0001);
  endtask

  task automatic t_sib;
    logic [31:0] exp_sc [4];
    exp_sc = '{32'h1010, 32'h1020, 32'h1040, 32'h1080};
    for (int s = 0; s < 4; s++) begin
      issue(1'b1, 2'b00, 3'd4, s[1:0], 3'd6, 3'd3, 32'h0000_0999, 1'b0, 3'd0);
      check($sformatf("R5 scale%0d", s), offset, exp_sc[s]);
      check("R7 EBX base DS", {29'b0, seg}, 32'd3);
    end
    issue(1'b1, 2'b00, 3'd4, 2'd3, 3'd4, 3'd3, 32'h0000_0000, 1'b0, 3'd0);
    check("R5 no index", offset, 32'h0000_1000);
    issue(1'b1, 2'b01, 3'd4, 2'd0, 3'd4, 3'd4, 32'h0000_0008, 1'b0, 3'd0);
    check("R5 ESP base", offset, 32'h0000_7008);
    check("R7 ESP seg SS", {29'b0, seg}, 32'd2);
    issue(1'b1, 2'b00, 3'd4, 2'd1, 3'd1, 3'd5, 32'h0000_0400, 1'b0, 3'd0);
    check("R6 no base disp32", offset, 32'h0000_0404);
    check("R6 seg DS", {29'b0, seg}, 32'd3);
    issue(1'b1, 2'b01, 3'd4, 2'd1, 3'd1, 3'd5, 32'h0000_0008, 1'b0, 3'd0);
    check("R7 SIB EBP base", offset, 32'h0000_800C);
    check("R7 SIB EBP seg SS", {29'b0, seg}, 32'd2);
  endtask

  task automatic t_override;
    issue(1'b0, 2'b01, 3'd2, 2'd0, 3'd0, 3'd0, 32'h0, 1'b1, 3'd4);
    check("R8 override FS", {29'b0, seg}, 32'd4);
    issue(1'b1, 2'b00, 3'd3, 2'd0, 3'd0, 3'd0, 32'h0, 1'b1, 3'd0);
    check("R8 override ES", {29'b0, seg}, 32'd0);
    issue(1'b1, 2'b10, 3'd5, 2'd0, 3'd0, 3'd0, 32'h0, 1'b1, 3'd5);
    check("R8 override GS over SS", {29'b0, seg}, 32'd5);
  endtask

  task automatic t_regform;
    issue(1'b1, 2'b11, 3'd6, 2'd0, 3'd0, 3'd0, 32'h5555_5555, 1'b1, 3'd4);
    check("R9 is_reg", {31'b0, is_reg}, 32'd1);
    check("R9 reg_sel", {29'b0, reg_sel}, 32'd6);
    check("R9 offset zero", offset, 32'd0);
    check("R9 seg DS", {29'b0, seg}, 32'd3);
  endtask

  task automatic t_hold;
    issue(1'b1, 2'b01, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_0001, 1'b0, 3'd0);
    check("R10 first result", offset, 32'h0000_0101);
    addr32 = 1'b1; mod_f = 2'b11; rm_f = 3'd2; disp = 32'hFFFF_0000;
    seg_ovr_valid = 1'b1; seg_ovr = 3'd1; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 idle out_valid", {31'b0, out_valid}, 32'd0);
    check("R10 idle offset held", offset, 32'h0000_0101);
    check("R10 idle seg held", {29'b0, seg}, 32'd3);
    check("R10 idle is_reg held", {31'b0, is_reg}, 32'd0);
    check("R10 idle reg_sel held", {29'b0, reg_sel}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; addr32 = 1'b0; mod_f = 2'b00; rm_f = 3'd0;
    sib_scale = 2'd0; sib_index = 3'd0; sib_base = 3'd0; disp = '0;
    gpr_flat = '0; seg_ovr_valid = 1'b0; seg_ovr = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    t_reset();
    t_mode16();
    t_mode32();
    t_sib();
    t_override();
    t_regform();
    t_hold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule